// File: doc/BRIEF.md
# Reseeding Scan Self-Test Sequencer

This block runs a scan-based self-test whose patterns come from a small shift-register generator that is reloaded ("reseeded") from a seed store. The seeds are taken in the order they are stored. Each seed is loaded into the generator, and the generator's serial output is shifted into the scan chains for exactly one chain length of cycles. The sequencer then drops scan enable and issues a launch pulse followed by a capture pulse at system speed, and raises scan enable again so that the captured response is shifted out while the next pattern is shifted in. The responses that leave the chains are folded into a multiple-input signature register. The final signature is compared against a golden value supplied at start.

A schedule input sets how many patterns each seed expands into. The generator keeps running between patterns of the same seed, so every extra pattern is pseudo-random. Schedule 0 expands every seed into d patterns, with d taken from a small set. Schedule 1 expands only the first seed into d patterns, with d taken from a large set. Schedule 2 expands the first two seeds. The seed limit k caps how many stored seeds are used. Seed computation and the circuit under test lie outside the block.

The seed port is valid/ready. The sequencer raises `seed_ready` only while it is waiting for the next seed, and it holds `seed_idx` stable for that whole wait. A seed is taken in the cycle where `seed_valid` and `seed_ready` are both high. The store may hold `seed_valid` low for any number of cycles, which stalls the sequencer with no shifting. `seed_data` is only sampled at the transfer. All other pins are plain levels.

Top module: `reseed_bist_ctrl`

## Requirements
- R1: The generator is a 4-bit shift register with output bit s[0], shifting right, with new s[3] = s[0] xor s[3]; scan_si[c] carries state bit c mod LFSR_W. Loaded with seed 4'b0111, its first ten serial bits during shifting are 1,1,1,0,1,0,1,1,0,0, so a 10-bit chain fed at position 0 ends holding 0011010111 read from position 0 to 9.
- R2: Seeds are loaded only through a valid/ready transfer (lfsr_load high). They are loaded in index order 0..k-1, exactly k of them. Between patterns of one seed the generator is not reloaded.
- R3: Every shift-in window has shift_en and scan_en high for exactly CHAIN_LEN consecutive cycles. After the last capture, one further window of CHAIN_LEN cycles flushes the final response.
- R4: After each shift-in, scan_en goes low for exactly two cycles with cap_en high in both (the launch pulse, then the capture pulse). scan_en is high again before the next shift. cap_en is never high while scan_en is high.
- R5: With sched_sel 0, every seed yields d patterns, for d in {1,2,4,8}.
- R6: With sched_sel 1, the first seed yields d patterns and every later seed yields one, for d in {1024,2048,4096}.
- R7: With sched_sel 2, the first two seeds each yield d patterns and every later seed yields one, for d in {1024,2048,4096}.
- R8: A d that is not a power of two, a d outside the set allowed for the schedule, or sched_sel 3 is rejected. In that case done rises two cycles after start, pass stays 0, and no seed, shift or capture is issued.
- R9: With k = 0, done rises two cycles after start, with no seed load, shift or capture pulse. The signature stays 0, so pass is 1 exactly when golden is 0.
- R10: cmp_en is high only on shift cycles that carry out a captured response. It is low during the first shift-in after start and high during every later shift window and the flush. The signature starts at 0 and updates as sig = {sig[14:0],0} xor (sig[15] ? 16'h1021 : 0) xor resp.
- R11: done stays high from the end of the flush until the next start. While done is high, pass is 1 exactly when the signature equals the golden value latched at start.
- R12: While seed_ready is high and seed_valid is low, the sequencer waits with shift_en and cap_en low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Starts a run when idle or done |
| sched_sel | input | 2 | Expansion schedule: 0 every seed, 1 first seed, 2 first two seeds |
| d_sel | input | D_W | Patterns per expanded seed |
| seed_limit | input | K_W | Number of seeds k to apply |
| golden | input | SIG_W | Expected final signature |
| seed_valid | input | 1 | Seed store has the seed at seed_idx |
| seed_data | input | LFSR_W | Seed value |
| seed_ready | output | 1 | Sequencer waits for a seed |
| seed_idx | output | K_W | Index of the seed requested |
| lfsr_load | output | 1 | Generator loads seed_data this cycle |
| shift_en | output | 1 | Scan-chain and generator shift clock enable |
| scan_en | output | 1 | Scan mode select, low for launch and capture |
| cap_en | output | 1 | At-speed launch/capture clock enable |
| cmp_en | output | 1 | Signature register update enable |
| scan_si | output | N_CH | Serial data into each chain |
| resp_in | input | N_CH | Serial response from each chain |
| done | output | 1 | Run finished |
| pass | output | 1 | Signature matches golden (valid with done) |

## Verification
Each run is checked for its capture-pulse count, shift and compaction cycle counts, seed load order and final pass. Many short random runs with schedule 0 vary d, k, the seed contents and seed-port stalls. These separate a per-seed count error from a per-run error, and show whether the sequencer keeps counting correctly through back-pressure. Single long runs under schedules 1 and 2 with k = 3 separate "first seed only" from "first two seeds": the expected pattern totals, 1026 and 2049, differ. Directed runs cover the literal serial sequence of seed 0111, a deliberately wrong golden value, k = 0, and each rejected d. The rejected d values are 3, 2048 under schedule 0, 8 under schedule 1, and schedule 3.

// File: rtl/bist_ctrl_pkg.sv
package bist_ctrl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_CFG, ST_FETCH, ST_SHIFT, ST_LAUNCH, ST_CAPTURE, ST_FLUSH, ST_DONE
  } bist_state_e;

  localparam logic [1:0] SCH_EVERY  = 2'd0;
  localparam logic [1:0] SCH_FIRST1 = 2'd1;
  localparam logic [1:0] SCH_FIRST2 = 2'd2;
endpackage

// File: rtl/bist_lfsr.sv
module bist_lfsr #(
  parameter int          W    = 4,
  parameter logic [W-1:0] TAP = 4'b1001,
  parameter int          NCH  = 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [W-1:0]   seed,
  input  logic           en,
  output logic [NCH-1:0] si
);
  logic [W-1:0] st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    st <= '0;
    else if (load) st <= seed;
    else if (en)   st <= {^(st & TAP), st[W-1:1]};
  end

  // Each chain taps a different state bit so parallel chains differ.
  for (genvar c = 0; c < NCH; c++) begin : g_tap
    assign si[c] = st[c % W];
  end
endmodule

// File: rtl/bist_misr.sv
module bist_misr #(
  parameter int            SW   = 16,
  parameter logic [SW-1:0] POLY = 16'h1021,
  parameter int            NCH  = 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic           en,
  input  logic [NCH-1:0] resp,
  output logic [SW-1:0]  sig
);
  localparam int PAD = SW - NCH;
  logic [SW-1:0] fold;

  assign fold = {{PAD{1'b0}}, resp};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   sig <= '0;
    else if (clr) sig <= '0;
    else if (en)  sig <= {sig[SW-2:0], 1'b0} ^ (sig[SW-1] ? POLY : '0) ^ fold;
  end
endmodule

// File: rtl/bist_seq.sv
module bist_seq
  import bist_ctrl_pkg::*;
#(
  parameter int CHAIN_LEN   = 10,
  parameter int D_W         = 13,
  parameter int K_W         = 4,
  parameter int D_SMALL_MAX = 8,
  parameter int D_LARGE_MIN = 1024,
  parameter int D_LARGE_MAX = 4096
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [1:0]     sched_i,
  input  logic [D_W-1:0] dval_i,
  input  logic [K_W-1:0] kval_i,
  input  logic           seed_valid,
  output logic           seed_ready,
  output logic [K_W-1:0] seed_idx,
  output logic           lfsr_load,
  output logic           shift_en,
  output logic           scan_en,
  output logic           cap_en,
  output logic           cmp_en,
  output logic           accept,
  output logic           cfg_bad,
  output logic           done
);
  localparam int CW = $clog2(CHAIN_LEN + 1);
  localparam logic [CW-1:0]  LAST   = CW'(CHAIN_LEN - 1);
  localparam logic [D_W-1:0] SM_MAX = D_W'(D_SMALL_MAX);
  localparam logic [D_W-1:0] LG_MIN = D_W'(D_LARGE_MIN);
  localparam logic [D_W-1:0] LG_MAX = D_W'(D_LARGE_MAX);

  bist_state_e    state;
  logic [1:0]     sched_q;
  logic [D_W-1:0] d_q, pat_left, seed_pats;
  logic [K_W-1:0] k_q;
  logic [CW-1:0]  sh_cnt;
  logic           have_resp;
  logic           pow2, small_ok, large_ok, cfg_ok, expanded;

  // Configuration check on the start inputs.
  assign pow2     = (dval_i != '0) && ((dval_i & (dval_i - 1'b1)) == '0);
  assign small_ok = pow2 && (dval_i <= SM_MAX);
  assign large_ok = pow2 && (dval_i >= LG_MIN) && (dval_i <= LG_MAX);
  assign cfg_ok   = ((sched_i == SCH_EVERY) && small_ok) ||
                    (((sched_i == SCH_FIRST1) || (sched_i == SCH_FIRST2)) && large_ok);

  // Patterns for the seed at seed_idx.
  assign expanded  = (sched_q == SCH_EVERY) ||
                     ((sched_q == SCH_FIRST1) && (seed_idx == '0)) ||
                     ((sched_q == SCH_FIRST2) && (seed_idx < K_W'(2)));
  assign seed_pats = expanded ? d_q : D_W'(1);

  assign accept     = ((state == ST_IDLE) || (state == ST_DONE)) && start;
  assign seed_ready = (state == ST_FETCH);
  assign lfsr_load  = seed_ready && seed_valid;
  assign shift_en   = (state == ST_SHIFT) || (state == ST_FLUSH);
  assign cap_en     = (state == ST_LAUNCH) || (state == ST_CAPTURE);
  assign scan_en    = !cap_en;
  assign cmp_en     = ((state == ST_SHIFT) && have_resp) || (state == ST_FLUSH);
  assign done       = (state == ST_DONE);
  assign cfg_bad    = 1'b0 | bad_q;

  logic bad_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      sched_q   <= '0;
      d_q       <= '0;
      k_q       <= '0;
      bad_q     <= 1'b0;
      seed_idx  <= '0;
      pat_left  <= '0;
      sh_cnt    <= '0;
      have_resp <= 1'b0;
    end else begin
      case (state)
        ST_IDLE, ST_DONE: if (start) begin
          state     <= ST_CFG;
          sched_q   <= sched_i;
          d_q       <= dval_i;
          k_q       <= kval_i;
          bad_q     <= !cfg_ok;
          seed_idx  <= '0;
          sh_cnt    <= '0;
          have_resp <= 1'b0;
        end
        ST_CFG: state <= (bad_q || (k_q == '0)) ? ST_DONE : ST_FETCH;
        ST_FETCH: if (seed_valid) begin
          pat_left <= seed_pats;
          seed_idx <= seed_idx + 1'b1;
          sh_cnt   <= '0;
          state    <= ST_SHIFT;
        end
        ST_SHIFT: if (sh_cnt == LAST) begin
          sh_cnt <= '0;
          state  <= ST_LAUNCH;
        end else begin
          sh_cnt <= sh_cnt + 1'b1;
        end
        ST_LAUNCH: state <= ST_CAPTURE;
        ST_CAPTURE: begin
          have_resp <= 1'b1;
          if (pat_left > D_W'(1)) begin
            pat_left <= pat_left - 1'b1;
            state    <= ST_SHIFT;
          end else if (seed_idx < k_q) begin
            state <= ST_FETCH;
          end else begin
            state <= ST_FLUSH;
          end
        end
        ST_FLUSH: if (sh_cnt == LAST) begin
          sh_cnt <= '0;
          state  <= ST_DONE;
        end else begin
          sh_cnt <= sh_cnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/reseed_bist_ctrl.sv
module reseed_bist_ctrl #(
  parameter int               LFSR_W    = 4,
  parameter logic [LFSR_W-1:0] TAP      = 4'b1001,
  parameter int               N_CH      = 1,
  parameter int               CHAIN_LEN = 10,
  parameter int               D_W       = 13,
  parameter int               K_W       = 4,
  parameter int               SIG_W     = 16,
  parameter logic [SIG_W-1:0] POLY      = 16'h1021
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        sched_sel,
  input  logic [D_W-1:0]    d_sel,
  input  logic [K_W-1:0]    seed_limit,
  input  logic [SIG_W-1:0]  golden,
  input  logic              seed_valid,
  input  logic [LFSR_W-1:0] seed_data,
  output logic              seed_ready,
  output logic [K_W-1:0]    seed_idx,
  output logic              lfsr_load,
  output logic              shift_en,
  output logic              scan_en,
  output logic              cap_en,
  output logic              cmp_en,
  output logic [N_CH-1:0]   scan_si,
  input  logic [N_CH-1:0]   resp_in,
  output logic              done,
  output logic              pass
);
  logic             accept, cfg_bad;
  logic [SIG_W-1:0] sig, gold_q;

  bist_seq #(.CHAIN_LEN(CHAIN_LEN), .D_W(D_W), .K_W(K_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .sched_i(sched_sel),
    .dval_i(d_sel), .kval_i(seed_limit), .seed_valid(seed_valid),
    .seed_ready(seed_ready), .seed_idx(seed_idx), .lfsr_load(lfsr_load),
    .shift_en(shift_en), .scan_en(scan_en), .cap_en(cap_en), .cmp_en(cmp_en),
    .accept(accept), .cfg_bad(cfg_bad), .done(done)
  );

  bist_lfsr #(.W(LFSR_W), .TAP(TAP), .NCH(N_CH)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .load(lfsr_load), .seed(seed_data),
    .en(shift_en), .si(scan_si)
  );

  bist_misr #(.SW(SIG_W), .POLY(POLY), .NCH(N_CH)) u_misr (
    .clk(clk), .rst_n(rst_n), .clr(accept), .en(cmp_en), .resp(resp_in), .sig(sig)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      gold_q <= '0;
    else if (accept) gold_q <= golden;
  end

  assign pass = done && !cfg_bad && (sig == gold_q);
endmodule

// File: rtl/bist_ctrl_chk.sv
module bist_ctrl_chk #(
  parameter int CHAIN_LEN = 10
) (
  input logic clk,
  input logic rst_n,
  input logic seed_valid,
  input logic seed_ready,
  input logic lfsr_load,
  input logic shift_en,
  input logic scan_en,
  input logic cap_en,
  input logic cmp_en,
  input logic done
);
  logic [15:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        run_cnt <= '0;
    else if (shift_en) run_cnt <= run_cnt + 1'b1;
    else               run_cnt <= '0;
  end

  a_r4_cap_se_low: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |-> !scan_en);
  a_r4_pair_second: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_en && !$past(cap_en)) |=> cap_en);
  a_r4_pair_end: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_en && $past(cap_en)) |=> !cap_en);
  a_r3_shift_run: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scan_en) |-> (run_cnt == 16'(CHAIN_LEN)));
  a_r10_cmp_in_shift: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_en |-> (shift_en && scan_en));
  a_r2_load_handshake: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_load |-> (seed_valid && seed_ready));
  a_r12_stall_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (seed_ready && !seed_valid) |-> (!shift_en && !cap_en));
  a_r11_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!shift_en && !cap_en && !seed_ready));
endmodule

bind reseed_bist_ctrl bist_ctrl_chk #(.CHAIN_LEN(CHAIN_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .seed_valid(seed_valid), .seed_ready(seed_ready),
  .lfsr_load(lfsr_load), .shift_en(shift_en), .scan_en(scan_en),
  .cap_en(cap_en), .cmp_en(cmp_en), .done(done)
);

// File: tb/reseed_bist_ctrl_test.sv
module reseed_bist_ctrl_test;
  localparam int M = 10;

  logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [1:0]  sched_sel = '0;
  logic [12:0] d_sel = '0;
  logic [3:0]  seed_limit = '0;
  logic [15:0] golden = '0;
  logic        seed_valid = 1'b0;
  logic [3:0]  seed_data;
  logic        seed_ready, lfsr_load, shift_en, scan_en, cap_en, cmp_en, done, pass;
  logic [3:0]  seed_idx;
  logic [0:0]  scan_si, resp_in;

  logic [3:0]   smem [16];
  logic [M-1:0] chain = '0;
  bit           chain_clr = 0, stall = 0, mon = 0;
  int tests = 0, fails = 0;
  int cap_n, sh_n, cmp_n, ld_n, ord_err, ser_n;
  bit ser [20];

  always #2 clk = ~clk;

  reseed_bist_ctrl uut (
    .clk(clk), .rst_n(rst_n), .start(start), .sched_sel(sched_sel), .d_sel(d_sel),
    .seed_limit(seed_limit), .golden(golden), .seed_valid(seed_valid),
    .seed_data(seed_data), .seed_ready(seed_ready), .seed_idx(seed_idx),
    .lfsr_load(lfsr_load), .shift_en(shift_en), .scan_en(scan_en), .cap_en(cap_en),
    .cmp_en(cmp_en), .scan_si(scan_si), .resp_in(resp_in), .done(done), .pass(pass)
  );

  function automatic logic [M-1:0] capf(input logic [M-1:0] c);
    return {c[M-2:0], c[M-1]} ^ (c >> 2) ^ M'(1);
  endfunction

  function automatic logic [15:0] misr(input logic [15:0] s, input logic b);
    return {s[14:0], 1'b0} ^ (s[15] ? 16'h1021 : 16'h0) ^ {15'd0, b};
  endfunction

  function automatic int pats(input int sc, input int d, input int i);
    if (sc == 0) return d;
    return (i < ((sc == 1) ? 1 : 2)) ? d : 1;
  endfunction

  // Stand-in scan chain and seed store.
  assign seed_data = smem[seed_idx];
  assign resp_in   = chain[M-1];
  always @(posedge clk) begin
    if (chain_clr)     chain <= '0;
    else if (shift_en) chain <= {chain[M-2:0], scan_si[0]};
    else if (cap_en)   chain <= capf(chain);
    seed_valid <= stall ? ($urandom % 3 == 0) : 1'b1;
  end

  always @(negedge clk) if (mon) begin
    if (cap_en) cap_n++;
    if (shift_en) sh_n++;
    if (cmp_en) cmp_n++;
    if (lfsr_load) begin
      if (seed_idx != 4'(ld_n)) ord_err++;
      ld_n++;
    end
    if (shift_en && ser_n < 20) begin ser[ser_n] = scan_si[0]; ser_n++; end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Independent reference run: generator, chain and signature.
  task automatic model(input int sc, input int d, input int k, output logic [15:0] sig, output int p);
    logic [3:0] s; logic [M-1:0] ch; bit have; logic b;
    sig = '0; p = 0; ch = '0; have = 0; s = '0;
    for (int i = 0; i < k; i++) begin
      s = smem[i];
      for (int q = 0; q < pats(sc, d, i); q++) begin
        for (int j = 0; j < M; j++) begin
          if (have) sig = misr(sig, ch[M-1]);
          b = s[0]; s = {s[0] ^ s[3], s[3:1]};
          ch = {ch[M-2:0], b};
        end
        ch = capf(capf(ch)); have = 1; p++;
      end
    end
    if (k > 0) for (int j = 0; j < M; j++) begin
      sig = misr(sig, ch[M-1]); ch = {ch[M-2:0], 1'b0};
    end
  endtask

  task automatic run(input int sc, input int d, input int k, input bit good, input bit bad,
                     input string rq);
    logic [15:0] es; int p, cyc; bit ep;
    model(sc, d, k, es, p);
    if (bad) p = 0;
    ep = good && !bad;
    @(negedge clk);
    sched_sel = 2'(sc); d_sel = 13'(d); seed_limit = 4'(k);
    golden = good ? es : es ^ 16'h0001;
    cap_n = 0; sh_n = 0; cmp_n = 0; ld_n = 0; ord_err = 0; ser_n = 0;
    start = 1; chain_clr = 1;
    @(negedge clk);
    start = 0; chain_clr = 0; mon = 1; cyc = 1;
    while (!done && cyc < 60000) begin @(negedge clk); cyc++; end
    mon = 0;
    check(cap_n == 2 * p, rq, cap_n, 2 * p);                        // pulse pairs per pattern
    check(sh_n == ((p > 0) ? (p + 1) * M : 0), "R3", sh_n, (p > 0) ? (p + 1) * M : 0);
    check(cmp_n == p * M, "R10", cmp_n, p * M);
    check(ld_n == (bad ? 0 : k) && ord_err == 0, "R2", ld_n, bad ? 0 : k);
    check(pass == ep, bad ? "R8" : "R11", pass, ep);
    if (bad || k == 0) check(cyc == 2, bad ? "R8" : "R9", cyc, 2);
  endtask

  initial begin
    int r;
    r = $urandom(32'hB157);
    for (int i = 0; i < 16; i++) smem[i] = 4'($urandom);
    repeat (3) @(negedge clk);
    check(!done && !cap_en && !shift_en && !seed_ready && scan_en, "R11", done, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R1: literal serial sequence of seed 0111, two patterns from one seed (R5).
    smem[0] = 4'b0111;
    run(0, 2, 1, 1, 0, "R5");
    begin
      bit exp1 [10] = '{1,1,1,0,1,0,1,1,0,0};
      for (int j = 0; j < 10; j++) check(ser[j] == exp1[j], "R1", ser[j], exp1[j]);
    end
    check(done == 1, "R11", done, 1);
    repeat (5) @(negedge clk);
    check(done == 1, "R11", done, 1);

    run(0, 4, 3, 0, 0, "R5");                          // wrong golden -> pass low (R11)
    run(0, 1, 0, 1, 0, "R9");                          // empty seed list
    run(0, 3, 2, 1, 1, "R8");                          // not a power of two
    run(0, 2048, 2, 1, 1, "R8");                       // large d under schedule 0
    run(1, 8, 2, 1, 1, "R8");                          // small d under schedule 1
    run(3, 1024, 2, 1, 1, "R8");                       // reserved schedule
    stall = 1; run(0, 8, 4, 1, 0, "R12"); stall = 0;   // back-pressure

    for (int t = 0; t < 12; t++) begin
      int dd, kk;
      for (int i = 0; i < 16; i++) smem[i] = 4'($urandom);
      dd = 1 << ($urandom % 4);
      kk = 1 + $urandom % 8;
      stall = ($urandom % 2 == 1);
      run(0, dd, kk, 1, 0, "R5");
    end
    stall = 0;

    run(1, 1024, 3, 1, 0, "R6");
    stall = 1; run(2, 1024, 3, 1, 0, "R7"); stall = 0;

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule